// File: doc/BRIEF.md
# I2C Bus Hang Injector

This block is a test-support I2C controller whose only job is to leave the bus hung on purpose, so that a target's recovery logic can be exercised. Software or a test sequencer picks one of three hang points, gives a 7-bit target address, a register byte and a bit count, and pulses a start input. The block then drives a partial transaction through open-drain outputs, using the same start, transmit-bit and receive-bit primitives that a normal controller would use. Each primitive waits for SCL to read high before it moves on, so targets that stretch the clock are honoured.

At the hang point the block releases SDA, releases SCL, waits for SCL to read high (or for the stretch timeout to expire) and then stops. No stop condition is sent. Errors along the way are ignored: arbitration, a missing acknowledge or a stretch timeout never cut the sequence short. Once the hang point is reached, the block records the SDA and SCL levels it sampled and raises a done flag. It stays parked, with both lines released, until a separate release input returns it to idle.

Top module: `i2c_hang_inject`

## Requirements
- R1: After reset both line outputs are released (scl_low_o = 0, sda_low_o = 0) and busy_o and done_o are low.
- R2: With mode_i = 0 (mode 3 acts the same), the bus shows a start condition, then the seven address bits MSB first, then a 0 direction bit, then one more SCL rise with SDA released. That final rise is the hang point.
- R3: With mode_i = 1, the bus shows: start, address with direction 0, an acknowledge slot, the register byte MSB first, an acknowledge slot, a repeated start, address with direction 1, an acknowledge slot, N receive slots with SDA released, then the hang rise.
- R4: With mode_i = 2, the bus shows: start, address with direction 0, an acknowledge slot, the first N bits of the register byte MSB first, then the hang rise with SDA released.
- R5: A bit count above 8 is treated as 8. A bit count of 0 puts the hang rise directly after the last acknowledge slot.
- R6: No stop condition is ever produced. SDA is released only while the block itself holds SCL low. From the hang point until release, both line outputs stay released and no further SCL rise occurs.
- R7: Each SCL high phase starts only after SCL reads high. A target that holds SCL low for fewer than STRETCH_MAX cycles leaves the bit sequence unchanged.
- R8: If SCL does not read high within STRETCH_MAX + 1 cycles, the block carries on regardless. At the hang point this still raises done_o, with cap_scl_o = 0.
- R9: When done_o rises, cap_sda_o and cap_scl_o hold the SDA and SCL levels sampled at the hang point. They stay unchanged until the next run.
- R10: A release_i pulse while done_o is high clears done_o on the next clock, leaves busy_o low and makes the block accept a new start.
- R11: A start_i pulse while busy_o or done_o is high has no effect on the bus sequence, the latched settings or the hung state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | One-cycle request to begin a hang sequence |
| mode_i | input | 2 | Hang point: 0 address acknowledge, 1 register read, 2 register write, 3 same as 0 |
| addr_i | input | 7 | Target address |
| reg_i | input | 8 | Register byte |
| nbits_i | input | 4 | Bits to clock before hanging (read and write modes), clamped to 8 |
| release_i | input | 1 | Leaves the hung state and returns to idle |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Hang point reached; block is parked |
| cap_sda_o | output | 1 | SDA level captured at the hang point |
| cap_scl_o | output | 1 | SCL level captured at the hang point |

## Verification
The hardest case to reach from the ports is a stretch timeout that lands exactly on the hang phase, while every earlier bit completes normally. The bench's bus model counts SCL rises and arms a stuck-low clamp on the falling edge that follows the last regular bit, so only the final high phase times out. The hang-time SDA capture is driven low the same way: the model pulls SDA low after the eighth address rise, as a real target acknowledging would. A second start pulse is injected both mid-sequence and while hung, to show that the latched settings survive.

// File: rtl/ihi_pkg.sv
package ihi_pkg;

    typedef enum logic [1:0] {
        HM_ACK     = 2'd0,
        HM_READ    = 2'd1,
        HM_WRITE   = 2'd2,
        HM_ACK_ALT = 2'd3
    } hang_mode_e;

    typedef enum logic [1:0] {
        OP_START,
        OP_TX,
        OP_RX,
        OP_HANG
    } line_op_e;

    typedef enum logic [3:0] {
        SG_START,
        SG_ADDR_W,
        SG_ACK_A,
        SG_REG,
        SG_ACK_R,
        SG_RESTART,
        SG_ADDR_R,
        SG_ACK_B,
        SG_RX_BITS,
        SG_TX_BITS,
        SG_HANG
    } seg_e;

endpackage

// File: rtl/ihi_timer.sv
module ihi_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ihi_linephy.sv
module ihi_linephy
    import ihi_pkg::*;
#(
    parameter int PHASE_CYC   = 4,
    parameter int STRETCH_MAX = 250
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_valid,
    input  line_op_e op,
    input  logic     op_bit,
    input  logic     release_i,
    input  logic     scl_i,
    input  logic     sda_i,
    output logic     op_done,
    output logic     hang_done,
    output logic     scl_low_o,
    output logic     sda_low_o,
    output logic     cap_sda_o,
    output logic     cap_scl_o
);
    localparam int TMAX = (PHASE_CYC > STRETCH_MAX) ? PHASE_CYC : STRETCH_MAX;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] PH_V  = TW'(PHASE_CYC);
    localparam logic [TW-1:0] STR_V = TW'(STRETCH_MAX);

    typedef enum logic [2:0] {
        PH_IDLE, PH_SETUP, PH_RISE, PH_HOLD, PH_SDA_FALL, PH_HUNG
    } ph_e;

    typedef struct packed {
        ph_e      ph;
        line_op_e op;
        logic     scl_low;
        logic     sda_low;
        logic     cap_sda;
        logic     cap_scl;
    } phy_st_t;

    phy_st_t s_d, s_q;
    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;

    ihi_timer #(.CNT_W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_comb begin
        s_d       = s_q;
        tmr_load  = 1'b0;
        tmr_val   = PH_V;
        op_done   = 1'b0;
        hang_done = 1'b0;
        case (s_q.ph)
            PH_IDLE: if (op_valid) begin
                s_d.op      = op;
                s_d.sda_low = (op == OP_TX) && !op_bit;
                s_d.ph      = PH_SETUP;
                tmr_load    = 1'b1;
            end
            PH_SETUP: if (tmr_exp) begin
                s_d.scl_low = 1'b0;
                s_d.ph      = PH_RISE;
                tmr_load    = 1'b1;
                tmr_val     = STR_V;
            end
            PH_RISE: if (scl_i || tmr_exp) begin
                if (s_q.op == OP_HANG) begin
                    s_d.cap_sda = sda_i;
                    s_d.cap_scl = scl_i;
                    s_d.ph      = PH_HUNG;
                    hang_done   = 1'b1;
                end else begin
                    s_d.ph   = PH_HOLD;
                    tmr_load = 1'b1;
                end
            end
            PH_HOLD: if (tmr_exp) begin
                if (s_q.op == OP_START) begin
                    s_d.sda_low = 1'b1;
                    s_d.ph      = PH_SDA_FALL;
                    tmr_load    = 1'b1;
                end else begin
                    s_d.scl_low = 1'b1;
                    s_d.ph      = PH_IDLE;
                    op_done     = 1'b1;
                end
            end
            PH_SDA_FALL: if (tmr_exp) begin
                s_d.scl_low = 1'b1;
                s_d.ph      = PH_IDLE;
                op_done     = 1'b1;
            end
            PH_HUNG: if (release_i) begin
                s_d.scl_low = 1'b0;
                s_d.sda_low = 1'b0;
                s_d.ph      = PH_IDLE;
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '{ph: PH_IDLE, op: OP_START, scl_low: 1'b0, sda_low: 1'b0,
                     cap_sda: 1'b0, cap_scl: 1'b0};
        else
            s_q <= s_d;
    end

    assign scl_low_o = s_q.scl_low;
    assign sda_low_o = s_q.sda_low;
    assign cap_sda_o = s_q.cap_sda;
    assign cap_scl_o = s_q.cap_scl;

    // R6: parked state never pulls a line
    assert_hang_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_HUNG) |-> (!s_q.scl_low && !s_q.sda_low));

    // R6: SDA goes released only while SCL is held low, so no stop can form
    assert_no_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.sda_low) |-> s_q.scl_low);

    // R6: SDA is pulled low with SCL high only for the start condition
    assert_sda_low_while_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.sda_low) |-> (s_q.scl_low || s_q.ph == PH_SDA_FALL));

    // R8: an expired stretch wait always moves on
    assert_stretch_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_RISE && tmr_exp) |=> (s_q.ph != PH_RISE));

    // R9: captured levels only change when the hang point is reached
    assert_capture_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_HUNG) |=> ($stable(s_q.cap_sda) && $stable(s_q.cap_scl)));

endmodule

// File: rtl/ihi_seq.sv
module ihi_seq
    import ihi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    input  logic [6:0] addr_i,
    input  logic [7:0] reg_i,
    input  logic [3:0] nbits_i,
    input  logic       release_i,
    input  logic       op_done,
    input  logic       hang_done,
    output logic       op_valid,
    output line_op_e   op,
    output logic       op_bit,
    output logic       busy_o,
    output logic       done_o
);
    localparam int BYTE_BITS = 8;
    localparam logic [3:0] MAX_NB = 4'(BYTE_BITS);

    typedef enum logic [1:0] { SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_HUNG } sq_e;

    typedef struct packed {
        sq_e        st;
        seg_e       seg;
        logic [3:0] idx;
        hang_mode_e mode;
        logic [6:0] addr;
        logic [7:0] regb;
        logic [3:0] nbits;
    } seq_st_t;

    seq_st_t s_d, s_q;

    function automatic logic [3:0] seg_len(seg_e s, logic [3:0] nb);
        case (s)
            SG_ADDR_W, SG_REG, SG_ADDR_R: return MAX_NB;
            SG_RX_BITS, SG_TX_BITS:       return nb;
            default:                      return 4'd1;
        endcase
    endfunction

    function automatic seg_e next_seg(seg_e s, hang_mode_e m, logic [3:0] nb);
        case (s)
            SG_START:   return SG_ADDR_W;
            SG_ADDR_W:  return (m == HM_READ || m == HM_WRITE) ? SG_ACK_A : SG_HANG;
            SG_ACK_A:   return (m == HM_READ) ? SG_REG : ((nb == '0) ? SG_HANG : SG_TX_BITS);
            SG_REG:     return SG_ACK_R;
            SG_ACK_R:   return SG_RESTART;
            SG_RESTART: return SG_ADDR_R;
            SG_ADDR_R:  return SG_ACK_B;
            SG_ACK_B:   return (nb == '0) ? SG_HANG : SG_RX_BITS;
            default:    return SG_HANG;
        endcase
    endfunction

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SQ_IDLE: if (start_i) begin
                s_d.mode  = hang_mode_e'(mode_i);
                s_d.addr  = addr_i;
                s_d.regb  = reg_i;
                s_d.nbits = (nbits_i > MAX_NB) ? MAX_NB : nbits_i;
                s_d.seg   = SG_START;
                s_d.idx   = '0;
                s_d.st    = SQ_ISSUE;
            end
            SQ_ISSUE: s_d.st = SQ_WAIT;
            SQ_WAIT: begin
                if (hang_done) begin
                    s_d.st = SQ_HUNG;
                end else if (op_done) begin
                    if (s_q.idx + 4'd1 < seg_len(s_q.seg, s_q.nbits)) begin
                        s_d.idx = s_q.idx + 4'd1;
                    end else begin
                        s_d.seg = next_seg(s_q.seg, s_q.mode, s_q.nbits);
                        s_d.idx = '0;
                    end
                    s_d.st = SQ_ISSUE;
                end
            end
            SQ_HUNG: if (release_i) s_d.st = SQ_IDLE;
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '{st: SQ_IDLE, seg: SG_START, idx: '0, mode: HM_ACK,
                     addr: '0, regb: '0, nbits: '0};
        else
            s_q <= s_d;
    end

    // Primitive decode: bytes go out MSB first
    logic [2:0] pos;
    always_comb begin
        pos    = 3'(BYTE_BITS - 1) - s_q.idx[2:0];
        op     = OP_RX;
        op_bit = 1'b1;
        case (s_q.seg)
            SG_START, SG_RESTART: op = OP_START;
            SG_HANG:              op = OP_HANG;
            SG_ADDR_W: begin op = OP_TX; op_bit = (s_q.addr & 7'h7f) != 0 ? {s_q.addr, 1'b0}[pos] : 1'b0; end
            SG_ADDR_R: begin op = OP_TX; op_bit = {s_q.addr, 1'b1}[pos]; end
            SG_REG, SG_TX_BITS: begin op = OP_TX; op_bit = s_q.regb[pos]; end
            default: op = OP_RX;
        endcase
    end

    assign op_valid = (s_q.st == SQ_ISSUE);
    assign busy_o   = (s_q.st == SQ_ISSUE) || (s_q.st == SQ_WAIT);
    assign done_o   = (s_q.st == SQ_HUNG);

    // R5: stored bit count never exceeds one byte
    assert_nbits_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != SQ_IDLE) |-> (s_q.nbits <= MAX_NB));

    // R11: a start while active leaves the latched settings alone
    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != SQ_IDLE && start_i) |=>
            ($stable(s_q.mode) && $stable(s_q.addr) && $stable(s_q.regb) && $stable(s_q.nbits)));

    // R10: release leaves the parked state on the next clock
    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && release_i) |=> (!done_o && !busy_o));

    // R10: done is only ever entered from an active sequence
    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o));

endmodule

// File: rtl/i2c_hang_inject.sv
module i2c_hang_inject
    import ihi_pkg::*;
#(
    parameter int PHASE_CYC   = 4,
    parameter int STRETCH_MAX = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    input  logic [6:0] addr_i,
    input  logic [7:0] reg_i,
    input  logic [3:0] nbits_i,
    input  logic       release_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_low_o,
    output logic       sda_low_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       cap_sda_o,
    output logic       cap_scl_o
);
    line_op_e op;
    logic     op_valid, op_bit, op_done, hang_done;

    ihi_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mode_i    (mode_i),
        .addr_i    (addr_i),
        .reg_i     (reg_i),
        .nbits_i   (nbits_i),
        .release_i (release_i),
        .op_done   (op_done),
        .hang_done (hang_done),
        .op_valid  (op_valid),
        .op        (op),
        .op_bit    (op_bit),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    ihi_linephy #(
        .PHASE_CYC   (PHASE_CYC),
        .STRETCH_MAX (STRETCH_MAX)
    ) u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op        (op),
        .op_bit    (op_bit),
        .release_i (release_i),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .op_done   (op_done),
        .hang_done (hang_done),
        .scl_low_o (scl_low_o),
        .sda_low_o (sda_low_o),
        .cap_sda_o (cap_sda_o),
        .cap_scl_o (cap_scl_o)
    );

endmodule

// File: tb/i2c_hang_inject_bench.sv
module i2c_hang_inject_bench;
    localparam int PH  = 2;
    localparam int STR = 40;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0, start_i = 1'b0, release_i = 1'b0;
    logic [1:0] mode_i = '0;
    logic [6:0] addr_i = '0;
    logic [7:0] reg_i = '0;
    logic [3:0] nbits_i = '0;
    logic       scl_low_o, sda_low_o, busy_o, done_o, cap_sda_o, cap_scl_o;
    logic       tgt_scl_low = 1'b0, tgt_sda_low = 1'b0;
    logic       scl_bus, sda_bus;

    assign scl_bus = !scl_low_o && !tgt_scl_low;
    assign sda_bus = !sda_low_o && !tgt_sda_low;

    i2c_hang_inject #(.PHASE_CYC(PH), .STRETCH_MAX(STR)) u_i2c_hang_inject (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .addr_i(addr_i), .reg_i(reg_i), .nbits_i(nbits_i), .release_i(release_i),
        .scl_i(scl_bus), .sda_i(sda_bus), .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
        .busy_o(busy_o), .done_o(done_o), .cap_sda_o(cap_sda_o), .cap_scl_o(cap_scl_o)
    );

    // Knobs written only by the stimulus process
    bit mon_en = 1'b0, clr_req = 1'b0, ack_pull = 1'b0, stuck_en = 1'b0;
    int stretch_k = 0, stuck_n = 0;

    // State written only by the bus model
    int   got[$];
    int   bitcnt = 0, str_cnt = 0, mon_vec = 0, mon_miss = 0;
    bit   stuck = 1'b0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;

    int chk_vec = 0, chk_miss = 0;
    int exp_q[$];

    // Behavioural bus: records every SCL rise and start, checks per clock
    always @(negedge clk) begin
        if (clr_req) begin
            got.delete();
            bitcnt = 0;
        end
        if (mon_en) begin
            mon_vec++;
            if (done_o && (busy_o || scl_low_o || sda_low_o)) begin
                mon_miss++;
                $display("FAIL R6 parked lines: got busy=%0d scl_low=%0d sda_low=%0d expected 0 0 0",
                         busy_o, scl_low_o, sda_low_o);
            end
            if (prev_scl && scl_bus && !prev_sda && sda_bus) begin
                mon_miss++;
                $display("FAIL R6 stop condition seen: got 1 expected 0");
            end
            if (!prev_scl && scl_bus) begin
                got.push_back(int'(sda_bus));
                bitcnt++;
            end else if (prev_scl && scl_bus && prev_sda && !sda_bus) begin
                got.push_back(2);
            end
            if (stuck_en && prev_scl && !scl_bus && bitcnt == stuck_n) stuck = 1'b1;
        end
        if (!stuck_en) stuck = 1'b0;
        if (scl_low_o) str_cnt = stretch_k;
        else if (str_cnt > 0) str_cnt--;
        tgt_scl_low = (str_cnt > 0) || stuck;
        if (!ack_pull) tgt_sda_low = 1'b0;
        else if (bitcnt == 8 && !scl_bus) tgt_sda_low = 1'b1;
        prev_scl = scl_bus;
        prev_sda = sda_bus;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv, input string what);
        chk_vec++;
        if (!ok) begin
            chk_miss++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic void build_exp(input int m, input int a, input int r, input int n, input bit pull);
        int nn = (n > 8) ? 8 : n;
        exp_q.delete();
        exp_q.push_back(2);
        for (int i = 6; i >= 0; i--) exp_q.push_back((a >> i) & 1);
        exp_q.push_back(0);
        if (m == 1) begin
            exp_q.push_back(1);
            for (int i = 7; i >= 0; i--) exp_q.push_back((r >> i) & 1);
            exp_q.push_back(1);
            exp_q.push_back(1);
            exp_q.push_back(2);
            for (int i = 6; i >= 0; i--) exp_q.push_back((a >> i) & 1);
            exp_q.push_back(1);
            exp_q.push_back(1);
            for (int i = 0; i < nn; i++) exp_q.push_back(1);
            exp_q.push_back(1);
        end else if (m == 2) begin
            exp_q.push_back(1);
            for (int i = 0; i < nn; i++) exp_q.push_back((r >> (7 - i)) & 1);
            exp_q.push_back(1);
        end else begin
            exp_q.push_back(pull ? 0 : 1);
        end
    endfunction

    task automatic pulse_start(input int m, input int a, input int r, input int n);
        @(negedge clk);
        mode_i = 2'(m); addr_i = 7'(a); reg_i = 8'(r); nbits_i = 4'(n); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_case(input int m, input int a, input int r, input int n, input int sk,
                            input bit pull, input bit stick, input bit poke,
                            input int exp_sda, input int exp_scl, input string req);
        int bits = 0;
        int w = 0;
        int bad = -1;
        build_exp(m, a, r, n, pull);
        foreach (exp_q[i]) if (exp_q[i] != 2) bits++;
        @(posedge clk);
        stretch_k = sk; ack_pull = pull; stuck_n = bits - 1; stuck_en = stick;
        clr_req = 1'b1; mon_en = 1'b1;
        @(posedge clk);
        clr_req = 1'b0;
        if (stick) void'(exp_q.pop_back());
        pulse_start(m, a, r, n);
        if (poke) begin
            repeat (10) @(negedge clk);
            chk(busy_o, "R11", int'(busy_o), 1, "busy before second start");
            pulse_start((m + 1) % 3, a ^ 7'h55, r ^ 8'hff, 8);
        end
        while (!done_o && w < 20000) begin
            @(negedge clk);
            w++;
        end
        chk(done_o, req, int'(done_o), 1, "hang point reached");
        repeat (6) @(negedge clk);
        chk(got.size() == exp_q.size(), req, got.size(), exp_q.size(), "bus event count");
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            if (bad < 0 && got[i] != exp_q[i]) bad = i;
        chk(bad < 0, req, (bad < 0) ? 0 : got[bad], (bad < 0) ? 0 : exp_q[bad],
            $sformatf("bus event at index %0d", bad));
        chk(cap_sda_o == 1'(exp_sda), "R9", int'(cap_sda_o), exp_sda, "captured SDA");
        chk(cap_scl_o == 1'(exp_scl), "R9", int'(cap_scl_o), exp_scl, "captured SCL");
        chk(done_o && !busy_o && !scl_low_o && !sda_low_o, "R6",
            int'({done_o, busy_o, scl_low_o, sda_low_o}), 8, "parked state");
        if (poke) begin
            pulse_start(2, 7'h11, 8'h22, 1);
            repeat (20) @(negedge clk);
            chk(done_o && !busy_o, "R11", int'({done_o, busy_o}), 2, "start while hung");
            chk(got.size() == exp_q.size(), "R11", got.size(), exp_q.size(), "events after start while hung");
        end
        @(negedge clk);
        release_i = 1'b1;
        @(negedge clk);
        release_i = 1'b0;
        chk(!done_o && !busy_o, "R10", int'({done_o, busy_o}), 0, "release returns to idle");
        @(posedge clk);
        mon_en = 1'b0; stuck_en = 1'b0; ack_pull = 1'b0; stretch_k = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", chk_vec + mon_vec + 1, chk_miss + mon_miss + 1);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(!busy_o && !done_o && !scl_low_o && !sda_low_o, "R1",
            int'({busy_o, done_o, scl_low_o, sda_low_o}), 0, "reset state");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R2 with an acknowledging target: R9 captures SDA low
        run_case(0, 7'h5a, 8'h00, 0, 0, 1'b1, 1'b0, 1'b0, 0, 1, "R2");
        // R2 via mode 3, nobody acknowledges
        run_case(3, 7'h23, 8'h00, 0, 0, 1'b0, 1'b0, 1'b0, 1, 1, "R2");
        // R3 read hang after three bits, second starts ignored (R11)
        run_case(1, 7'h48, 8'hc5, 3, 0, 1'b0, 1'b0, 1'b1, 1, 1, "R3");
        // R5 zero bits in read mode
        run_case(1, 7'h31, 8'h0f, 0, 0, 1'b0, 1'b0, 1'b0, 1, 1, "R5");
        // R4 write hang after five bits with a stretching target (R7)
        run_case(2, 7'h6c, 8'hb3, 5, 6, 1'b0, 1'b0, 1'b0, 1, 1, "R7");
        // R5 count above eight clamps to a full byte
        run_case(2, 7'h12, 8'h96, 12, 0, 1'b0, 1'b0, 1'b0, 1, 1, "R5");
        // R4 zero bits in write mode
        run_case(2, 7'h7f, 8'h3c, 0, 0, 1'b0, 1'b0, 1'b0, 1, 1, "R4");
        // R8 SCL stuck low on the hang phase only
        run_case(2, 7'h44, 8'ha7, 3, 0, 1'b0, 1'b1, 1'b0, 1, 0, "R8");
        $display("  == %0d vectors applied, %0d miscompares ==", chk_vec + mon_vec, chk_miss + mon_miss);
        $finish;
    end

endmodule